// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Registers

This block holds the interrupt and error state of a NAND-style flash controller, along with two system configuration words. Software reaches it through a single register port: it writes the interrupt word to acknowledge events, reads the error flags and sets the interrupt polarity and the ready line. A separate command engine reports finished work through strobes. Each strobe gives the operation type and a pass/fail flag, or marks an unknown command. The block then raises the master interrupt bit, the matching completion bit and, on failure, the error flags.

The interrupt pin can be active-high or active-low, chosen by a configuration bit. Acknowledging uses AND semantics: software writes a mask, and bits written as zero are cleared. Clearing the master bit also wipes every error flag. There are two reset inputs. A cold reset leaves a load-done indication in the interrupt word. A warm reset, which corresponds to a controller reset command, leaves a reset-done indication instead. The block contains no state machine. Its state is the interrupt word, the four error flags, the two configuration words and the ready flop, all updated together on each clock edge.

Top module: `flc_irq_regs`

## Requirements
- R1: After a cold reset the interrupt word reads 0x8080, status reads 0x0000, configuration 1 reads 0x40C0, configuration 2 reads 0x0000 and `rdy` is 1.
- R2: After a warm reset the interrupt word reads 0x8010, the error flags are clear, both configuration words return to their reset values and `rdy` is 1.
- R3: A completion strobe sets interrupt bit 15 and the done bit for `done_op`. The op codes map as follows: 0 reset sets bit 4, 1 erase sets bit 5, 2 program sets bit 6, 3 load sets bit 7. The result is visible one cycle after the strobe.
- R4: A completion strobe with `done_fail` also sets the command-error flag at status bit 10. For erase, program and load it sets the operation flag as well, at bits 11, 12 and 13. A failed reset op sets only bit 10.
- R5: An `unknown_cmd` strobe sets interrupt bit 15 and status bit 10, and sets no done bit.
- R6: A write to register select 0 (interrupt) replaces the interrupt word with the old word ANDed with `wr_data`. The write never sets a bit.
- R7: If bit 15 is clear after such a write, all four error flags clear. If bit 15 remains set, the error flags keep their values.
- R8: `irq` equals interrupt bit 15 when configuration-1 bit 6 is 1, and the inverse of bit 15 when it is 0. It follows register changes in the cycle after the update.
- R9: A write to select 2 (configuration 1) loads `rdy` from bit 7 of the written value. No other write changes `rdy`.
- R10: Configuration 1 (select 2) reads back masked with 0xFFE0. Configuration 2 (select 3) reads back in full. Status (select 1) places the flags at bits 10 to 13, and writes to select 1 are ignored.
- R11: When an interrupt write and a strobe occur in the same cycle, the AND is applied first and the strobe's bits are then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous cold reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write: 0 interrupt, 1 status, 2 config 1, 3 config 2 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `reg_sel` (combinational) |
| done_valid | input | 1 | Command completion strobe |
| done_op | input | 2 | Completed operation: 0 reset, 1 erase, 2 program, 3 load |
| done_fail | input | 1 | Completed operation failed |
| unknown_cmd | input | 1 | Unrecognised command strobe |
| irq | output | 1 | Interrupt pin, polarity from config 1 bit 6 |
| rdy | output | 1 | Ready pin |

## Verification
The assertions check several invariants on every cycle:
- No error flag exists without the master bit.
- Any operation error comes with the command-error flag.
- An acknowledge write never sets a bit.
- `rdy` holds unless configuration 1 is written.
- After any strobe, `irq` sits at its asserted level.

The exact reset values need the bench's scenarios. So do the mapping of op codes to bit positions, the read mask, the error wipe on clearing bit 15, both polarities, and the ordering when a write and a strobe share a cycle.

// File: rtl/flc_irq_pkg.sv
package flc_irq_pkg;
    localparam int WORD_W      = 16;
    localparam int MASTER_BIT  = 15;
    localparam int DONE_BASE   = 4;
    localparam int ERR_BASE    = 10;
    localparam int NUM_OPS     = 4;
    localparam int POL_BIT     = 6;
    localparam int RDY_BIT     = 7;

    typedef enum logic [1:0] {
        SEL_INT  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CFG1 = 2'd2,
        SEL_CFG2 = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2,
        OP_LOAD  = 2'd3
    } op_e;
endpackage

// File: rtl/flc_int_status.sv
module flc_int_status
    import flc_irq_pkg::*;
#(
    parameter int W        = WORD_W,
    parameter int NOPS     = NUM_OPS,
    parameter logic [W-1:0] COLD_VAL = 16'h8080,
    parameter logic [W-1:0] WARM_VAL = 16'h8010
) (
    input  logic            clk,
    input  logic            cold_rst,
    input  logic            warm_rst,
    input  logic            wr_int,
    input  logic [W-1:0]    wr_data,
    input  logic            ev_valid,
    input  logic [1:0]      ev_op,
    input  logic            ev_fail,
    input  logic            ev_unknown,
    output logic [W-1:0]    int_q,
    output logic [NOPS-1:0] err_q
);
    logic [W-1:0]    masked;
    logic [W-1:0]    set_int;
    logic [NOPS-1:0] set_err;
    logic [W-1:0]    int_d;
    logic [NOPS-1:0] err_d;

    always_comb begin
        set_int = '0;
        set_err = '0;
        if (ev_valid) begin
            set_int[MASTER_BIT] = 1'b1;
            for (int i = 0; i < NOPS; i++) begin
                if (ev_op == 2'(i)) begin
                    set_int[DONE_BASE + i] = 1'b1;
                    if (ev_fail) begin
                        set_err[0] = 1'b1;
                        set_err[i] = 1'b1;
                    end
                end
            end
        end
        if (ev_unknown) begin
            set_int[MASTER_BIT] = 1'b1;
            set_err[0]          = 1'b1;
        end
    end

    always_comb begin
        masked = wr_int ? (int_q & wr_data) : int_q;
        int_d  = masked | set_int;
        err_d  = (masked[MASTER_BIT] ? err_q : '0) | set_err;
    end

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            int_q <= COLD_VAL;
            err_q <= '0;
        end else if (warm_rst) begin
            int_q <= WARM_VAL;
            err_q <= '0;
        end else begin
            int_q <= int_d;
            err_q <= err_d;
        end
    end

    AST_ERR_NEEDS_MASTER: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (|err_q) |-> int_q[MASTER_BIT]); // R7
    AST_OPERR_HAS_CMDERR: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (|err_q[NOPS-1:1]) |-> err_q[0]); // R4
    AST_ACK_NEVER_SETS: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (wr_int && !ev_valid && !ev_unknown) |=> ((int_q & ~$past(int_q)) == '0)); // R6
    AST_UNKNOWN_FLAGS: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        ev_unknown |=> (int_q[MASTER_BIT] && err_q[0])); // R5
endmodule

// File: rtl/flc_cfg_regs.sv
module flc_cfg_regs
    import flc_irq_pkg::*;
#(
    parameter int W = WORD_W,
    parameter logic [W-1:0] CFG1_RST = 16'h40C0,
    parameter logic [W-1:0] CFG2_RST = 16'h0000
) (
    input  logic         clk,
    input  logic         cold_rst,
    input  logic         warm_rst,
    input  logic         wr_cfg1,
    input  logic         wr_cfg2,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cfg1_q,
    output logic [W-1:0] cfg2_q,
    output logic         rdy_q
);
    always_ff @(posedge clk) begin
        if (cold_rst || warm_rst) begin
            cfg1_q <= CFG1_RST;
            cfg2_q <= CFG2_RST;
            rdy_q  <= 1'b1;
        end else begin
            if (wr_cfg1) begin
                cfg1_q <= wr_data;
                rdy_q  <= wr_data[RDY_BIT];
            end
            if (wr_cfg2) begin
                cfg2_q <= wr_data;
            end
        end
    end

    AST_RDY_HOLDS: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        !wr_cfg1 |=> $stable(rdy_q)); // R9
endmodule

// File: rtl/flc_irq_regs.sv
module flc_irq_regs
    import flc_irq_pkg::*;
#(
    parameter int W = WORD_W,
    parameter logic [W-1:0] CFG1_RD_MASK = 16'hFFE0
) (
    input  logic         clk,
    input  logic         cold_rst,
    input  logic         warm_rst,
    input  logic         wr_en,
    input  logic [1:0]   reg_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         done_valid,
    input  logic [1:0]   done_op,
    input  logic         done_fail,
    input  logic         unknown_cmd,
    output logic         irq,
    output logic         rdy
);
    reg_sel_e             sel;
    logic [W-1:0]         int_q;
    logic [NUM_OPS-1:0]   err_q;
    logic [W-1:0]         cfg1_q;
    logic [W-1:0]         cfg2_q;

    assign sel = reg_sel_e'(reg_sel);

    flc_int_status #(.W(W), .NOPS(NUM_OPS)) u_int (
        .clk        (clk),
        .cold_rst   (cold_rst),
        .warm_rst   (warm_rst),
        .wr_int     (wr_en && (sel == SEL_INT)),
        .wr_data    (wr_data),
        .ev_valid   (done_valid),
        .ev_op      (done_op),
        .ev_fail    (done_fail),
        .ev_unknown (unknown_cmd),
        .int_q      (int_q),
        .err_q      (err_q)
    );

    flc_cfg_regs #(.W(W)) u_cfg (
        .clk      (clk),
        .cold_rst (cold_rst),
        .warm_rst (warm_rst),
        .wr_cfg1  (wr_en && (sel == SEL_CFG1)),
        .wr_cfg2  (wr_en && (sel == SEL_CFG2)),
        .wr_data  (wr_data),
        .cfg1_q   (cfg1_q),
        .cfg2_q   (cfg2_q),
        .rdy_q    (rdy)
    );

    always_comb begin
        unique case (sel)
            SEL_INT:  rd_data = int_q;
            SEL_STAT: rd_data = W'(err_q) << ERR_BASE;
            SEL_CFG1: rd_data = cfg1_q & CFG1_RD_MASK;
            SEL_CFG2: rd_data = cfg2_q;
            default:  rd_data = '0;
        endcase
    end

    assign irq = int_q[MASTER_BIT] ^ ~cfg1_q[POL_BIT];

    AST_IRQ_ASSERTED_AFTER_EVENT: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (done_valid || unknown_cmd) |=> (irq == cfg1_q[POL_BIT])); // R8
endmodule

// File: tb/tb_flc_irq_regs.sv
module tb_flc_irq_regs;
    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        done_valid = 1'b0;
    logic [1:0]  done_op = 2'd0;
    logic        done_fail = 1'b0;
    logic        unknown_cmd = 1'b0;
    logic        irq;
    logic        rdy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flc_irq_regs dut (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .wr_en(wr_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .done_valid(done_valid), .done_op(done_op), .done_fail(done_fail),
        .unknown_cmd(unknown_cmd), .irq(irq), .rdy(rdy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [15:0] exp);
        reg_sel = sel;
        #0.5;
        chk(req, rd_data, exp);
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic event_done(input logic [1:0] op, input logic fail);
        @(negedge clk);
        done_valid = 1'b1; done_op = op; done_fail = fail;
        @(negedge clk);
        done_valid = 1'b0; done_fail = 1'b0;
    endtask

    task automatic t_cold;
        rd_chk("R1 int", 2'd0, 16'h8080);
        rd_chk("R1 status", 2'd1, 16'h0000);
        rd_chk("R1 cfg1", 2'd2, 16'h40C0);
        rd_chk("R1 cfg2", 2'd3, 16'h0000);
        chk("R1 rdy", 16'(rdy), 16'd1);
        chk("R8 irq active-high set", 16'(irq), 16'd1);
    endtask

    task automatic t_events;
        reg_wr(2'd0, 16'h0000);
        rd_chk("R6 clear all", 2'd0, 16'h0000);
        chk("R8 irq low when clear", 16'(irq), 16'd0);
        event_done(2'd1, 1'b0);
        rd_chk("R3 erase done", 2'd0, 16'h8020);
        rd_chk("R3 no error", 2'd1, 16'h0000);
        event_done(2'd3, 1'b1);
        rd_chk("R3 load done", 2'd0, 16'h80A0);
        rd_chk("R4 load error", 2'd1, 16'h2400);
        event_done(2'd2, 1'b1);
        rd_chk("R4 program error", 2'd1, 16'h3400);
        rd_chk("R3 program done", 2'd0, 16'h80E0);
    endtask

    task automatic t_ack;
        reg_wr(2'd0, 16'hFFDF);
        rd_chk("R6 and mask", 2'd0, 16'h80C0);
        rd_chk("R7 errors kept", 2'd1, 16'h3400);
        reg_wr(2'd0, 16'h7FFF);
        rd_chk("R6 master cleared", 2'd0, 16'h00C0);
        rd_chk("R7 errors wiped", 2'd1, 16'h0000);
        chk("R8 irq after ack", 16'(irq), 16'd0);
    endtask

    task automatic t_unknown;
        reg_wr(2'd0, 16'h0000);
        @(negedge clk);
        unknown_cmd = 1'b1;
        @(negedge clk);
        unknown_cmd = 1'b0;
        rd_chk("R5 unknown int", 2'd0, 16'h8000);
        rd_chk("R5 unknown status", 2'd1, 16'h0400);
        reg_wr(2'd0, 16'h0000);
        event_done(2'd0, 1'b1);
        rd_chk("R4 reset op fail int", 2'd0, 16'h8010);
        rd_chk("R4 reset op fail status", 2'd1, 16'h0400);
        event_done(2'd1, 1'b1);
        rd_chk("R4 erase error", 2'd1, 16'h0C00);
    endtask

    task automatic t_polarity;
        reg_wr(2'd2, 16'h0000);
        rd_chk("R10 cfg1 zero", 2'd2, 16'h0000);
        chk("R9 rdy low", 16'(rdy), 16'd0);
        chk("R8 active-low set", 16'(irq), 16'd0);
        reg_wr(2'd0, 16'h0000);
        chk("R8 active-low clear", 16'(irq), 16'd1);
        chk("R9 rdy unchanged by int write", 16'(rdy), 16'd0);
        reg_wr(2'd2, 16'h00BF);
        rd_chk("R10 cfg1 mask", 2'd2, 16'h00A0);
        chk("R9 rdy high", 16'(rdy), 16'd1);
        chk("R8 active-low still", 16'(irq), 16'd1);
        reg_wr(2'd3, 16'h1234);
        rd_chk("R10 cfg2 full", 2'd3, 16'h1234);
        reg_wr(2'd1, 16'hFFFF);
        rd_chk("R10 status write ignored", 2'd1, 16'h0000);
        rd_chk("R10 int untouched by status write", 2'd0, 16'h0000);
        reg_wr(2'd2, 16'h40C0);
    endtask

    task automatic t_same_cycle;
        event_done(2'd3, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = 2'd0; wr_data = 16'h0000;
        done_valid = 1'b1; done_op = 2'd2; done_fail = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; done_valid = 1'b0;
        rd_chk("R11 event after and", 2'd0, 16'h8040);
    endtask

    task automatic t_warm;
        event_done(2'd3, 1'b1);
        reg_wr(2'd3, 16'hABCD);
        reg_wr(2'd2, 16'h0000);
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        rd_chk("R2 int", 2'd0, 16'h8010);
        rd_chk("R2 status", 2'd1, 16'h0000);
        rd_chk("R2 cfg1", 2'd2, 16'h40C0);
        rd_chk("R2 cfg2", 2'd3, 16'h0000);
        chk("R2 rdy", 16'(rdy), 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cold_rst = 1'b0;
        t_cold();
        t_events();
        t_ack();
        t_unknown();
        t_polarity();
        t_same_cycle();
        t_warm();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule